// File: doc/BRIEF.md
# SMI Interrupt Routing Unit

This block turns selected interrupt request lines into one active-low system-management interrupt request and keeps a sticky status bit per source. Four sources belong to on-board devices (parallel port, two serial ports, floppy controller). Each is routed through whatever line number that device is currently configured to use, so moving a device to another line moves its source with it. Three more sources sit on fixed lines, by default 12, 1 and 10.

Software reaches four byte-wide registers through a two-bit selector: a device enable byte, a fixed-line enable byte, a device status byte and a fixed-line status byte. A read of a status byte merges the latched source bits into the stored byte under a fixed keep-mask. Writing a 1 to a source position of a status byte clears that latched bit.

Top module: `smi_router`

## Requirements
- R1: Selector 0 is the device enable byte, fully writable and read back as written; bit 1 enables the parallel source, bit 2 serial 2, bit 3 serial 1 and bit 4 the floppy source.
- R2: Selector 1 is the fixed-line enable byte, fully writable and read back as written; bit 0 enables line 12, bit 1 line 1 and bit 7 line 10.
- R3: A device source watches the line whose number is on that device's number input in the current cycle. Changing the number reroutes it at once. A line that is already high when it becomes selected does not count as an edge.
- R4: A source's status bit latches at the clock edge where its line is high and was low at the previous edge, provided its enable bit is set. A level held high, or an edge while the source is disabled, latches nothing.
- R5: Selector 2 reads as (stored byte AND 0xE1), with bits 1, 2, 3 and 4 replaced by the latched parallel, serial 2, serial 1 and floppy status bits.
- R6: Selector 3 reads as (stored byte AND 0xEC), with bits 0, 1 and 4 replaced by the latched line 12, line 1 and line 10 status bits.
- R7: A write to a status byte stores the written byte for the keep-mask positions. A 1 at a source position clears that latched bit and a 0 leaves it alone. A new edge in the same cycle as its clear leaves the bit set.
- R8: smi_n is low while any latched status bit is set and high otherwise; stored keep-mask bits and enable bits do not drive it, and clearing an enable leaves an already latched bit in place.
- R9: Reset clears both enable bytes, both stored status bytes and all latched bits, so every register reads 0x00 and smi_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | Interrupt request lines, active high |
| lpt_irq_sel | input | IRQ_W | Line number used by the parallel port |
| ser2_irq_sel | input | IRQ_W | Line number used by serial port 2 |
| ser1_irq_sel | input | IRQ_W | Line number used by serial port 1 |
| fdc_irq_sel | input | IRQ_W | Line number used by the floppy controller |
| reg_sel | input | 2 | Register selector: 0 device enable, 1 fixed enable, 2 device status, 3 fixed status |
| reg_wr | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| smi_n | output | 1 | System-management interrupt request, active low |

## Verification
On every cycle, the assertions check these properties: an enabled edge always leaves its status bit set, a clear with no competing edge always empties the bit, and no bit appears without an edge. They also check that rising edges never repeat on consecutive cycles, that enable writes are stored, and that smi_n only falls after an enabled hit. The keep-mask merge of each status byte, rerouting onto a line that is already high, the set-over-clear race and the reset values are shown only by the bench's scenarios, which read the registers at the ports.

// File: rtl/smi_route_pkg.sv
package smi_route_pkg;

    localparam int BYTE_W   = 8;
    // device sources: 0 parallel, 1 serial 2, 2 serial 1, 3 floppy
    localparam int DEV_SRCS = 4;
    // fixed sources: 0 first line, 1 second line, 2 third line
    localparam int FIX_SRCS = 3;

    localparam logic [BYTE_W-1:0] DEV_ST_KEEP = 8'hE1;
    localparam logic [BYTE_W-1:0] FIX_ST_KEEP = 8'hEC;

    typedef enum logic [1:0] {
        SEL_DEV_EN = 2'd0,
        SEL_FIX_EN = 2'd1,
        SEL_DEV_ST = 2'd2,
        SEL_FIX_ST = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dev_en;
        logic [BYTE_W-1:0] fix_en;
        logic [BYTE_W-1:0] dev_st_raw;
        logic [BYTE_W-1:0] fix_st_raw;
    } cfg_t;

    // device enable and status share one bit position per source
    function automatic int dev_bit(input int i);
        return i + 1;
    endfunction

    function automatic int fix_en_bit(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            default: return 7;
        endcase
    endfunction

    function automatic int fix_st_bit(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/smi_edge_detect.sv
module smi_edge_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = lines_i & ~st_q.prev;

    // R4: a line that rose is remembered high, so it cannot rise again next cycle
    a_r4_single_cycle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/smi_line_pick.sv
module smi_line_pick #(
    parameter int NUM_IRQ = 16,
    parameter int IRQ_W   = $clog2(NUM_IRQ)
) (
    input  logic [IRQ_W-1:0]   num_i,
    input  logic [NUM_IRQ-1:0] lines_i,
    output logic               pick_o
);

    generate
        if ((1 << IRQ_W) == NUM_IRQ) begin : g_full
            assign pick_o = lines_i[num_i];
        end else begin : g_guard
            logic [(1 << IRQ_W)-1:0] padded;
            assign padded = {{((1 << IRQ_W) - NUM_IRQ){1'b0}}, lines_i};
            assign pick_o = padded[num_i];
        end
    endgenerate

endmodule

// File: rtl/smi_sticky.sv
module smi_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    typedef struct packed {
        logic [N-1:0] stat;
    } sticky_st_t;

    sticky_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a new hit outranks a clear in the same cycle
        st_d.stat = (st_q.stat & ~clr_i) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;

    a_r4_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((stat_o & $past(hit_i)) == $past(hit_i)));

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i == '0) |=> ((stat_o & ~$past(stat_o)) == '0));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((stat_o & $past(clr_i & ~hit_i)) == '0));

endmodule

// File: rtl/smi_router.sv
module smi_router
    import smi_route_pkg::*;
#(
    parameter int NUM_IRQ   = 16,
    parameter int IRQ_W     = $clog2(NUM_IRQ),
    parameter int FIX0_LINE = 12,
    parameter int FIX1_LINE = 1,
    parameter int FIX2_LINE = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_lines,
    input  logic [IRQ_W-1:0]    lpt_irq_sel,
    input  logic [IRQ_W-1:0]    ser2_irq_sel,
    input  logic [IRQ_W-1:0]    ser1_irq_sel,
    input  logic [IRQ_W-1:0]    fdc_irq_sel,
    input  logic [1:0]          reg_sel,
    input  logic                reg_wr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    output logic                smi_n
);

    cfg_t cfg_d, cfg_q;

    logic [NUM_IRQ-1:0]  rise_all;
    logic [IRQ_W-1:0]    dev_num [DEV_SRCS];
    logic [DEV_SRCS-1:0] dev_rise, dev_hit, dev_clr, dev_stat;
    logic [FIX_SRCS-1:0] fix_rise, fix_hit, fix_clr, fix_stat;
    logic                wr_dev_st, wr_fix_st;

    assign wr_dev_st = reg_wr && (reg_sel == SEL_DEV_ST);
    assign wr_fix_st = reg_wr && (reg_sel == SEL_FIX_ST);

    assign dev_num[0] = lpt_irq_sel;
    assign dev_num[1] = ser2_irq_sel;
    assign dev_num[2] = ser1_irq_sel;
    assign dev_num[3] = fdc_irq_sel;

    smi_edge_detect #(.W(NUM_IRQ)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines),
        .rise_o  (rise_all)
    );

    generate
        for (genvar g = 0; g < DEV_SRCS; g++) begin : g_dev
            smi_line_pick #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_pick (
                .num_i   (dev_num[g]),
                .lines_i (rise_all),
                .pick_o  (dev_rise[g])
            );
            assign dev_hit[g] = dev_rise[g] & cfg_q.dev_en[dev_bit(g)];
            assign dev_clr[g] = wr_dev_st & reg_wdata[dev_bit(g)];
        end

        for (genvar g = 0; g < FIX_SRCS; g++) begin : g_fix
            localparam int LN = (g == 0) ? FIX0_LINE : (g == 1) ? FIX1_LINE : FIX2_LINE;
            assign fix_rise[g] = rise_all[LN];
            assign fix_hit[g]  = fix_rise[g] & cfg_q.fix_en[fix_en_bit(g)];
            assign fix_clr[g]  = wr_fix_st & reg_wdata[fix_st_bit(g)];
        end
    endgenerate

    smi_sticky #(.N(DEV_SRCS)) u_dev_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (dev_hit),
        .clr_i  (dev_clr),
        .stat_o (dev_stat)
    );

    smi_sticky #(.N(FIX_SRCS)) u_fix_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (fix_hit),
        .clr_i  (fix_clr),
        .stat_o (fix_stat)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_DEV_EN: cfg_d.dev_en     = reg_wdata;
                SEL_FIX_EN: cfg_d.fix_en     = reg_wdata;
                SEL_DEV_ST: cfg_d.dev_st_raw = reg_wdata;
                SEL_FIX_ST: cfg_d.fix_st_raw = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_DEV_EN: reg_rdata = cfg_q.dev_en;
            SEL_FIX_EN: reg_rdata = cfg_q.fix_en;
            SEL_DEV_ST: begin
                reg_rdata = cfg_q.dev_st_raw & DEV_ST_KEEP;
                for (int i = 0; i < DEV_SRCS; i++) begin
                    reg_rdata[dev_bit(i)] = dev_stat[i];
                end
            end
            SEL_FIX_ST: begin
                reg_rdata = cfg_q.fix_st_raw & FIX_ST_KEEP;
                for (int i = 0; i < FIX_SRCS; i++) begin
                    reg_rdata[fix_st_bit(i)] = fix_stat[i];
                end
            end
            default: ;
        endcase
    end

    assign smi_n = ~((|dev_stat) | (|fix_stat));

    a_r1_dev_en_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == SEL_DEV_EN)) |=> (cfg_q.dev_en == $past(reg_wdata)));

    a_r2_fix_en_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == SEL_FIX_EN)) |=> (cfg_q.fix_en == $past(reg_wdata)));

    a_r8_smi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n) |-> $past((dev_hit != '0) || (fix_hit != '0)));

endmodule

// File: tb/sim_smi_router.sv
module sim_smi_router;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines;
    logic [3:0]  lpt_irq_sel, ser2_irq_sel, ser1_irq_sel, fdc_irq_sel;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        smi_n;

    always #(CLK_P/2) clk = ~clk;

    smi_router u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_lines    (irq_lines),
        .lpt_irq_sel  (lpt_irq_sel),
        .ser2_irq_sel (ser2_irq_sel),
        .ser1_irq_sel (ser1_irq_sel),
        .fdc_irq_sel  (fdc_irq_sel),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .smi_n        (smi_n)
    );

    typedef struct {
        bit       is_smi;
        bit [1:0] sel;
        logic [7:0] exp;
        string    tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        item_t      it;
        logic [7:0] act;
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                it  = q.pop_front();
                act = it.is_smi ? {7'b0, smi_n} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: sel=%0d actual=%02h expected=%02h",
                             it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input bit [1:0] sel, input logic [7:0] exp, input string tag);
        item_t it;
        reg_sel = sel;
        #1;
        it.is_smi = 1'b0; it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic expect_smi(input logic exp, input string tag);
        item_t it;
        #1;
        it.is_smi = 1'b1; it.sel = reg_sel; it.exp = {7'b0, exp}; it.tag = tag;
        q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic wr(input bit [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        irq_lines[line] = 1'b1;
        @(negedge clk);
        irq_lines[line] = 1'b0;
    endtask

    task automatic set_line(input int line, input logic v);
        @(negedge clk);
        irq_lines[line] = v;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        irq_lines = '0;
        lpt_irq_sel = 4'd7; ser2_irq_sel = 4'd3; ser1_irq_sel = 4'd4; fdc_irq_sel = 4'd6;
        reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        for (int s = 0; s < 4; s++) expect_rd(2'(s), 8'h00, "R9 reset read");
        expect_smi(1'b1, "R9 reset smi_n");

        // R1 / R2 enable storage
        wr(2'd0, 8'hFF); expect_rd(2'd0, 8'hFF, "R1 dev enable readback");
        wr(2'd1, 8'h5A); expect_rd(2'd1, 8'h5A, "R2 fix enable readback");

        // R4 / R5 / R8 parallel source only
        wr(2'd0, 8'h02);
        pulse(7);
        expect_rd(2'd2, 8'h02, "R5 parallel status bit1");
        expect_smi(1'b0, "R8 smi asserted");
        pulse(4);
        expect_rd(2'd2, 8'h02, "R4 disabled serial1 edge ignored");
        wr(2'd2, 8'h02);
        expect_rd(2'd2, 8'h00, "R7 w1c clears parallel");
        expect_smi(1'b1, "R8 smi released");

        // R5 / R7 keep-mask
        wr(2'd2, 8'hFF);
        expect_rd(2'd2, 8'hE1, "R5 keep mask E1");
        expect_smi(1'b1, "R8 stored bits do not assert smi");
        wr(2'd2, 8'h00);
        expect_rd(2'd2, 8'h00, "R7 stored bits rewritten");

        // R3 rerouting of the floppy source
        wr(2'd0, 8'h10);
        @(negedge clk); fdc_irq_sel = 4'd9;
        pulse(6);
        expect_rd(2'd2, 8'h00, "R3 old floppy line ignored");
        pulse(9);
        expect_rd(2'd2, 8'h10, "R3 floppy follows new line");
        wr(2'd2, 8'h10);
        set_line(11, 1'b1);
        fdc_irq_sel = 4'd11;
        @(negedge clk);
        expect_rd(2'd2, 8'h00, "R3 line already high is not an edge");
        set_line(11, 1'b0);

        // R4 / R7 level held high, clear does not relatch
        wr(2'd0, 8'h08);
        set_line(4, 1'b1);
        expect_rd(2'd2, 8'h08, "R4 serial1 latched");
        wr(2'd2, 8'h08);
        expect_rd(2'd2, 8'h00, "R4 held level does not relatch");
        set_line(4, 1'b0);

        // R8 disable after latch keeps request
        wr(2'd0, 8'h04);
        pulse(3);
        expect_rd(2'd2, 8'h04, "R5 serial2 bit2");
        wr(2'd0, 8'h00);
        expect_rd(2'd2, 8'h04, "R8 latched bit survives disable");
        expect_smi(1'b0, "R8 smi held after disable");
        wr(2'd2, 8'h04);
        expect_smi(1'b1, "R8 smi released after clear");

        // R6 fixed lines
        wr(2'd1, 8'h83);
        pulse(12); expect_rd(2'd3, 8'h01, "R6 line12 bit0");
        pulse(1);  expect_rd(2'd3, 8'h03, "R6 line1 bit1");
        pulse(10); expect_rd(2'd3, 8'h13, "R6 line10 bit4");
        expect_smi(1'b0, "R8 smi from fixed lines");
        wr(2'd3, 8'hFF);
        expect_rd(2'd3, 8'hEC, "R6 keep mask EC and R7 clears");
        expect_smi(1'b1, "R8 smi after fixed clear");
        wr(2'd3, 8'h00);
        expect_rd(2'd3, 8'h00, "R7 fixed stored rewritten");
        wr(2'd1, 8'h01);
        pulse(10);
        expect_rd(2'd3, 8'h00, "R2 line10 disabled by bit7");
        pulse(12);
        expect_rd(2'd3, 8'h01, "R2 line12 enabled by bit0");
        wr(2'd3, 8'h01);

        // R7 edge in the clearing cycle wins
        wr(2'd0, 8'h02);
        @(negedge clk);
        irq_lines[7] = 1'b1;
        reg_sel = 2'd2; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(negedge clk);
        irq_lines[7] = 1'b0; reg_wr = 1'b0;
        expect_rd(2'd2, 8'h02, "R7 set wins over clear");

        // R9 reset during operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) expect_rd(2'(s), 8'h00, "R9 reset clears registers");
        expect_smi(1'b1, "R9 reset releases smi");
        rst_n = 1'b1;
        @(negedge clk);

        #2;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule